// File: doc/BRIEF.md
# Grouped Wallace tree multiplier

This block multiplies two unsigned operands with no clock. Each bit pair of the operands is ANDed to form a partial product, which gives eight shifted rows. The rows go through a reduction tree of three levels and come out as one exact product that is twice the operand width.

In the first level, the eight rows form two groups of four neighbouring rows. Each group is reduced on its own into a sum row and a carry row. In every column the reducer picks a cell to suit the number of bits present there:
- a 4:2 compressor (two full adders in series) where four or more bits meet,
- a full adder for three bits,
- a half adder for two bits,
- a plain wire for a single bit.

Each compressor passes a carry-out to the column above it, and that column counts the carry as one of its inputs.

The second level reduces the four rows left after the first level in the same way. The third level is a ripple-carry adder that merges the final two rows into the product. The operand width is a parameter from 2 to 8. The block is a drop-in combinational datapath element for a filter tap or any other arithmetic path.

Top module: `grouped_tree_mult`

## Requirements
- R1: For every pair of operands, `product` equals the exact unsigned product `mcand * mplier`.
- R2: When either operand is zero, `product` is zero.
- R3: When one operand is 1, `product` equals the other operand, zero-extended.
- R4: With both operands all ones, the product is the largest possible value. For the default width of 8 that is 255 x 255 = 65025 (0xFE01).
- R5: Swapping the two operands leaves `product` unchanged.
- R6: When `mplier` has exactly one bit set, at position k, `product` equals `mcand` shifted left by k.
- R7: The block is purely combinational. `product` follows an input change within the same time step, with no clock edge in between.
- R8: The two first-level row groups give exact results on their own. An `mplier` with only its low four bits set (0x0F) uses only the lower group, and one with only its high four bits set (0xF0) uses only the upper group. Both give the exact product for every `mcand`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand | input | OP_W | Unsigned multiplicand |
| mplier | input | OP_W | Unsigned multiplier; bit i selects partial-product row i |
| product | output | 2*OP_W | Exact unsigned product |

## Verification
Two of this block's functions meet in the same evaluation:
- the carry-out chain running through the compressor columns of a group;
- the ripple carry in the final adder.

Wrong handling of a chained carry only shows up when both are active at once. Dense operands provoke this: both operands all ones, and the alternating-bit patterns that sit inside the exhaustive sweep. Under them the compressor chain carries across every full-width column, and the final adder ripples from the low columns to the top bit. Each result is judged against the arithmetic product computed in the bench. Operand swaps and single-group multipliers then separate a fault in one group from a fault in the later levels.

// File: rtl/wtm_pkg.sv
package wtm_pkg;

  localparam int MAXW = 64;
  typedef logic [MAXW-1:0] mask_t;

  // Columns occupied by partial-product row `row` for operands of width opw.
  function automatic mask_t pp_mask(int row, int opw);
    mask_t m;
    m = '0;
    if (row < opw) begin
      for (int k = 0; k < opw; k++) m[row+k] = 1'b1;
    end
    return m;
  endfunction

  // Number of row bits present in column c.
  function automatic int col_cnt(mask_t m0, mask_t m1, mask_t m2, mask_t m3, int c);
    return (m0[c] ? 1 : 0) + (m1[c] ? 1 : 0) + (m2[c] ? 1 : 0) + (m3[c] ? 1 : 0);
  endfunction

  // True when column c holds a 4:2 compressor (four or more inputs,
  // counting the carry-out of a compressor in column c-1).
  function automatic bit cmp_at(mask_t m0, mask_t m1, mask_t m2, mask_t m3, int c);
    bit prev;
    int e;
    prev = 1'b0;
    for (int k = 0; k <= c; k++) begin
      e    = col_cnt(m0, m1, m2, m3, k) + (prev ? 1 : 0);
      prev = (e >= 4);
    end
    return prev;
  endfunction

  function automatic bit cin_at(mask_t m0, mask_t m1, mask_t m2, mask_t m3, int c);
    if (c == 0) return 1'b0;
    return cmp_at(m0, m1, m2, m3, c - 1);
  endfunction

  function automatic int eff_at(mask_t m0, mask_t m1, mask_t m2, mask_t m3, int c);
    return col_cnt(m0, m1, m2, m3, c) + (cin_at(m0, m1, m2, m3, c) ? 1 : 0);
  endfunction

  // Columns that carry a bit in the reduced sum row.
  function automatic mask_t sum_mask(mask_t m0, mask_t m1, mask_t m2, mask_t m3, int w);
    mask_t r;
    r = '0;
    for (int c = 0; c < w; c++) begin
      if (eff_at(m0, m1, m2, m3, c) >= 1) r[c] = 1'b1;
    end
    return r;
  endfunction

  // Columns that carry a bit in the reduced carry row (shifted by one).
  function automatic mask_t carry_mask(mask_t m0, mask_t m1, mask_t m2, mask_t m3, int w);
    mask_t r;
    r = '0;
    for (int c = 0; c < w - 1; c++) begin
      if (eff_at(m0, m1, m2, m3, c) >= 2) r[c+1] = 1'b1;
    end
    return r;
  endfunction

  // Index of the n-th set bit of pres; 5 selects a constant zero.
  function automatic int pick(logic [4:0] pres, int n);
    int seen;
    int res;
    seen = 0;
    res  = 5;
    for (int k = 0; k < 5; k++) begin
      if (pres[k]) begin
        if (seen == n && res == 5) res = k;
        seen++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/wtm_half_add.sv
module wtm_half_add (
  input  logic a,
  input  logic b,
  output logic sum,
  output logic carry
);
  assign sum   = a ^ b;
  assign carry = a & b;
endmodule

// File: rtl/wtm_full_add.sv
module wtm_full_add (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic sum,
  output logic carry
);
  assign sum   = a ^ b ^ c;
  assign carry = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/wtm_comp42.sv
// 4:2 compressor from two full adders in series.
// x1+x2+x3+x4+cin = sum + 2*(carry + cout); cout does not depend on cin.
module wtm_comp42 (
  input  logic x1,
  input  logic x2,
  input  logic x3,
  input  logic x4,
  input  logic cin,
  output logic sum,
  output logic carry,
  output logic cout
);
  logic s_mid;

  wtm_full_add u_fa_hi (.a(x1), .b(x2), .c(x3), .sum(s_mid), .carry(cout));
  wtm_full_add u_fa_lo (.a(s_mid), .b(x4), .c(cin), .sum(sum), .carry(carry));
endmodule

// File: rtl/wtm_pp_gen.sv
// AND-array partial products: row i holds mcand & mplier[i] shifted by i.
module wtm_pp_gen #(
  parameter int OP_W = 8,
  parameter int ROWS = 8,
  localparam int PW = 2 * OP_W
) (
  input  logic [OP_W-1:0]          mcand,
  input  logic [OP_W-1:0]          mplier,
  output logic [ROWS-1:0][PW-1:0]  rows
);
  for (genvar i = 0; i < ROWS; i++) begin : g_row
    for (genvar c = 0; c < PW; c++) begin : g_col
      if (i < OP_W && c >= i && c < i + OP_W) begin : g_and
        assign rows[i][c] = mcand[c-i] & mplier[i];
      end else begin : g_zero
        assign rows[i][c] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/wtm_group_reduce.sv
// Reduces four rows (occupancy given by constant masks) to a sum row and a
// carry row, choosing the cell of each column from its input count.
module wtm_group_reduce #(
  parameter int W = 16,
  parameter wtm_pkg::mask_t M0 = '0,
  parameter wtm_pkg::mask_t M1 = '0,
  parameter wtm_pkg::mask_t M2 = '0,
  parameter wtm_pkg::mask_t M3 = '0
) (
  input  logic [W-1:0] row0,
  input  logic [W-1:0] row1,
  input  logic [W-1:0] row2,
  input  logic [W-1:0] row3,
  output logic [W-1:0] sum_row,
  output logic [W-1:0] carry_row
);
  import wtm_pkg::*;

  logic [W-1:0] co;
  logic [W-1:0] s_col;
  logic [W-1:0] c_col;

  for (genvar c = 0; c < W; c++) begin : g_col
    localparam int         CNT   = col_cnt(M0, M1, M2, M3, c);
    localparam bit         CIN_P = cin_at(M0, M1, M2, M3, c);
    localparam int         EFF   = CNT + (CIN_P ? 1 : 0);
    localparam logic [4:0] PR    = {1'b0, M3[c], M2[c], M1[c], M0[c]};
    localparam logic [4:0] PA    = {CIN_P, M3[c], M2[c], M1[c], M0[c]};
    localparam int         R0 = pick(PR, 0);
    localparam int         R1 = pick(PR, 1);
    localparam int         R2 = pick(PR, 2);
    localparam int         R3 = pick(PR, 3);
    localparam int         A0 = pick(PA, 0);
    localparam int         A1 = pick(PA, 1);
    localparam int         A2 = pick(PA, 2);

    logic       cin;
    logic [5:0] v;
    logic       col_unused;

    if (CIN_P) begin : g_cin
      assign cin = co[c-1];
    end else begin : g_nocin
      assign cin = 1'b0;
    end

    assign v          = {1'b0, cin, row3[c], row2[c], row1[c], row0[c]};
    assign col_unused = ^v;

    if (EFF >= 4) begin : g_cmp
      wtm_comp42 u_cmp (
        .x1(v[R0]), .x2(v[R1]), .x3(v[R2]), .x4(v[R3]), .cin(cin),
        .sum(s_col[c]), .carry(c_col[c]), .cout(co[c])
      );
    end else if (EFF == 3) begin : g_fa
      wtm_full_add u_fa (.a(v[A0]), .b(v[A1]), .c(v[A2]), .sum(s_col[c]), .carry(c_col[c]));
      assign co[c] = 1'b0;
    end else if (EFF == 2) begin : g_ha
      wtm_half_add u_ha (.a(v[A0]), .b(v[A1]), .sum(s_col[c]), .carry(c_col[c]));
      assign co[c] = 1'b0;
    end else if (EFF == 1) begin : g_wire
      assign s_col[c] = v[A0];
      assign c_col[c] = 1'b0;
      assign co[c]    = 1'b0;
    end else begin : g_empty
      assign s_col[c] = 1'b0;
      assign c_col[c] = 1'b0;
      assign co[c]    = 1'b0;
    end
  end

  // Weight beyond the top column is dropped: the product always fits.
  logic tail_unused;
  assign tail_unused = co[W-1] ^ c_col[W-1];

  assign sum_row   = s_col;
  assign carry_row = {c_col[W-2:0], 1'b0};
endmodule

// File: rtl/wtm_ripple_add.sv
module wtm_ripple_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  logic [W:0] c;
  logic       ovf_unused;

  assign c[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_bit
    wtm_full_add u_fa (.a(a[i]), .b(b[i]), .c(c[i]), .sum(sum[i]), .carry(c[i+1]));
  end
  assign ovf_unused = c[W];
endmodule

// File: rtl/grouped_tree_mult.sv
module grouped_tree_mult #(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0]   mcand,
  input  logic [OP_W-1:0]   mplier,
  output logic [2*OP_W-1:0] product
);
  import wtm_pkg::*;

  localparam int PW     = 2 * OP_W;
  localparam int ROWS   = 8;
  localparam int GROUPS = ROWS / 4;

  // First-level output occupancy, group 0 and group 1.
  localparam mask_t LA_S0 = sum_mask(pp_mask(0, OP_W), pp_mask(1, OP_W),
                                     pp_mask(2, OP_W), pp_mask(3, OP_W), PW);
  localparam mask_t LA_C0 = carry_mask(pp_mask(0, OP_W), pp_mask(1, OP_W),
                                       pp_mask(2, OP_W), pp_mask(3, OP_W), PW);
  localparam mask_t LA_S1 = sum_mask(pp_mask(4, OP_W), pp_mask(5, OP_W),
                                     pp_mask(6, OP_W), pp_mask(7, OP_W), PW);
  localparam mask_t LA_C1 = carry_mask(pp_mask(4, OP_W), pp_mask(5, OP_W),
                                       pp_mask(6, OP_W), pp_mask(7, OP_W), PW);

  logic [ROWS-1:0][PW-1:0]   pp;
  logic [GROUPS-1:0][PW-1:0] la_s;
  logic [GROUPS-1:0][PW-1:0] la_c;
  logic [PW-1:0]             lb_s;
  logic [PW-1:0]             lb_c;

  wtm_pp_gen #(.OP_W(OP_W), .ROWS(ROWS)) u_pp (
    .mcand(mcand), .mplier(mplier), .rows(pp)
  );

  // Level A: each group of four neighbouring rows reduced on its own.
  for (genvar g = 0; g < GROUPS; g++) begin : g_lvl_a
    wtm_group_reduce #(
      .W (PW),
      .M0(pp_mask(4*g + 0, OP_W)),
      .M1(pp_mask(4*g + 1, OP_W)),
      .M2(pp_mask(4*g + 2, OP_W)),
      .M3(pp_mask(4*g + 3, OP_W))
    ) u_red (
      .row0(pp[4*g + 0]), .row1(pp[4*g + 1]), .row2(pp[4*g + 2]), .row3(pp[4*g + 3]),
      .sum_row(la_s[g]), .carry_row(la_c[g])
    );
  end

  // Level B: the four first-level rows reduced the same way.
  wtm_group_reduce #(
    .W(PW), .M0(LA_S0), .M1(LA_C0), .M2(LA_S1), .M3(LA_C1)
  ) u_lvl_b (
    .row0(la_s[0]), .row1(la_c[0]), .row2(la_s[1]), .row3(la_c[1]),
    .sum_row(lb_s), .carry_row(lb_c)
  );

  // Level C: carry-propagate merge of the last two rows.
  wtm_ripple_add #(.W(PW)) u_lvl_c (.a(lb_s), .b(lb_c), .sum(product));
endmodule

// File: rtl/grouped_tree_mult_chk.sv
module grouped_tree_mult_chk #(
  parameter int OP_W = 8
) (
  input logic [OP_W-1:0]   mcand,
  input logic [OP_W-1:0]   mplier,
  input logic [2*OP_W-1:0] product
);
  localparam int PW = 2 * OP_W;
  localparam logic [PW-1:0] TOP_PROD = PW'({OP_W{1'b1}}) * PW'({OP_W{1'b1}});

  always_comb begin
    if (!$isunknown({mcand, mplier, product})) begin
      assert_exact_product_R1: assert (product == PW'(mcand) * PW'(mplier))
        else $error("R1 product %0d for %0d x %0d", product, mcand, mplier);
      assert_zero_operand_R2: assert (!(mcand == '0 || mplier == '0) || product == '0)
        else $error("R2 nonzero product %0d", product);
      assert_identity_R3: assert (mplier != OP_W'(1) || product == PW'(mcand))
        else $error("R3 product %0d for mcand %0d", product, mcand);
      assert_top_value_R4: assert (!(&mcand && &mplier) || product == TOP_PROD)
        else $error("R4 product %0d", product);
    end
  end
endmodule

bind grouped_tree_mult grouped_tree_mult_chk #(.OP_W(OP_W)) u_chk (
  .mcand(mcand), .mplier(mplier), .product(product)
);

// File: tb/grouped_tree_mult_tb.sv
module grouped_tree_mult_tb;
  localparam int OP_W = 8;
  localparam int PW   = 2 * OP_W;

  logic            clk;
  logic [OP_W-1:0] mcand;
  logic [OP_W-1:0] mplier;
  logic [PW-1:0]   product;

  int checks;
  int errors;
  bit done;

  grouped_tree_mult #(.OP_W(OP_W)) u_dut (
    .mcand(mcand), .mplier(mplier), .product(product)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: mcand=%0d mplier=%0d actual=%0d expected=%0d", req, mcand, mplier, act, exp);
    end
  endtask

  // Drive after a rising edge, sample at the following falling edge.
  task automatic apply(input int a, input int b);
    @(posedge clk);
    mcand  = OP_W'(a);
    mplier = OP_W'(b);
    @(negedge clk);
  endtask

  function automatic logic [PW-1:0] ref_mul(input int a, input int b);
    return PW'(a * b);
  endfunction

  initial begin
    logic [PW-1:0] first;
    checks = 0;
    errors = 0;
    done   = 1'b0;
    mcand  = '0;
    mplier = '0;
    #1;
    check("R2", product, '0);

    // R1: exhaustive sweep against the arithmetic product.
    for (int a = 0; a < (1 << OP_W); a++) begin
      for (int b = 0; b < (1 << OP_W); b++) begin
        apply(a, b);
        check("R1", product, ref_mul(a, b));
      end
    end

    // R2: either operand zero.
    for (int a = 0; a < (1 << OP_W); a++) begin
      apply(a, 0);
      check("R2", product, '0);
      apply(0, a);
      check("R2", product, '0);
    end

    // R3: multiply by one on either side.
    for (int a = 0; a < (1 << OP_W); a++) begin
      apply(a, 1);
      check("R3", product, PW'(a));
      apply(1, a);
      check("R3", product, PW'(a));
    end

    // R4: both operands all ones, 255 x 255 = 65025.
    apply(255, 255);
    check("R4", product, 16'd65025);

    // R5: operand swap on dense and sparse patterns.
    for (int a = 1; a < (1 << OP_W); a += 7) begin
      for (int b = 0; b < (1 << OP_W); b += 13) begin
        apply(a, b);
        first = product;
        apply(b, a);
        check("R5", product, first);
      end
    end

    // R6: single-bit multiplier is a left shift.
    for (int k = 0; k < OP_W; k++) begin
      for (int a = 0; a < (1 << OP_W); a += 3) begin
        apply(a, 1 << k);
        check("R6", product, PW'(a) << k);
      end
    end

    // R7: combinational response with no clock edge in between.
    @(negedge clk);
    mcand  = 8'hAA;
    mplier = 8'h55;
    #1;
    check("R7", product, ref_mul(170, 85));
    mcand  = 8'hFF;
    mplier = 8'h81;
    #1;
    check("R7", product, ref_mul(255, 129));

    // R8: only the lower group, then only the upper group, active.
    for (int a = 0; a < (1 << OP_W); a++) begin
      apply(a, 8'h0F);
      check("R8", product, ref_mul(a, 15));
      apply(a, 8'hF0);
      check("R8", product, ref_mul(a, 240));
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Watchdog: about 100k cycles of margin beyond the planned run.
  initial begin
    #1_800_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule